// File: doc/BRIEF.md
# Two-Address Load-Store Register Machine

This block is a small processor core built around thirty-two general-purpose registers, each sixteen bits wide. It reaches memory only through explicit load and store instructions. Its one arithmetic operation is a two-address add: the instruction names two registers, adds them, and writes the sum back into the first one. Every instruction is exactly four bytes long. The core fetches them one byte per cycle from a byte-wide instruction port and runs each one in a single execute cycle after its fourth byte arrives. A full instruction therefore takes five cycles.

An instruction word is four bytes, with byte 0 at the lowest address. Byte 0 is the opcode. The low five bits of byte 1 hold the first register field. Load and store carry a memory address in bytes 2 and 3, with byte 2 as the high half. Add carries its second register field in the low five bits of byte 2. Every bit not used by an instruction must be zero. A violation, or an opcode the core does not know, stops the core and raises an illegal-encoding flag. Two running counters report memory traffic: one counts instruction bytes fetched, the other counts data bytes moved.

Top module: `lsm_core`

## Requirements
- R1: While reset is asserted, `halted`, `illegal`, both byte counters, `imem_addr`, `dmem_re` and `dmem_we` are all zero.
- R2: Instruction bytes are fetched from consecutive addresses starting at 0, four per instruction, with byte 0 of each instruction at the lowest address. After a HALT in slot k, `imem_addr` rests at 4*(k+1).
- R3: Opcode 0x20 (load) writes the 16-bit word at the address {byte2, byte3} into the register selected by byte1[4:0].
- R4: Opcode 0x21 (store) writes the register selected by byte1[4:0] to the address {byte2, byte3}, with `dmem_we` high for one cycle.
- R5: Opcode 0x22 (add) replaces register byte1[4:0] with the sum of that register and register byte2[4:0], modulo 2^16. When both fields name the same register, the result is that register doubled.
- R6: Register 0 is an ordinary register: it can be loaded, stored and used as either add operand.
- R7: Opcode 0xFF with bytes 1 to 3 all zero sets `halted` and leaves `illegal` low. Once halted, the core makes no further fetch progress and no data access, and `halted` stays high until reset.
- R8: A nonzero bit in any unused position sets both `illegal` and `halted`, and the instruction has no memory effect. The unused positions are: byte1[7:5] for every opcode; byte2[7:5] and all of byte3 for add; all of bytes 1 to 3 for halt.
- R9: Any opcode other than 0x20, 0x21, 0x22 and 0xFF sets `illegal` and `halted`.
- R10: `ibyte_cnt` grows by 4 for every instruction fully fetched, halting and illegal ones included. `dbyte_cnt` grows by 2 for each executed load or store and by 0 for add.
- R11: `dmem_re` and `dmem_we` are never high together, and each pulses for exactly one cycle per executed load or store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 16 | Byte address of the instruction byte being fetched |
| imem_rdata | input | 8 | Instruction byte at `imem_addr`, combinational |
| dmem_addr | output | 16 | Data word address |
| dmem_re | output | 1 | Data read strobe (load) |
| dmem_rdata | input | 16 | Data word at `dmem_addr`, combinational |
| dmem_we | output | 1 | Data write strobe (store) |
| dmem_wdata | output | 16 | Data word to write |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by a bad encoding |
| ibyte_cnt | output | 32 | Instruction bytes fetched |
| dbyte_cnt | output | 32 | Data bytes transferred |

## Verification
The add result can only be seen after it has been loaded into registers and stored back out, so it is reached indirectly. Each of the 1024 register pairs gets its own short program: load the first register, load the second one if it differs, add, store, halt. Each run starts from reset. The operand values are chosen so that many sums overflow 16 bits. The stored word then exposes the wrapped sum and the same-register doubling. Every padding bit of every opcode, and every unknown opcode, also gets its own program. Stores placed around the faulty instruction show that nothing reaches memory after it.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 16;
  localparam int ILEN   = 4;
  localparam int IW     = 8 * ILEN;

  localparam logic [7:0] OPC_LOAD  = 8'h20;
  localparam logic [7:0] OPC_STORE = 8'h21;
  localparam logic [7:0] OPC_ADD   = 8'h22;
  localparam logic [7:0] OPC_HALT  = 8'hFF;

  typedef enum logic [1:0] {K_LOAD, K_STORE, K_ADD, K_HALT} kind_e;

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic pad_clear(input kind_e k, input logic [IW-1:0] ir);
    case (k)
      K_LOAD, K_STORE: return ir[23:21] == 3'd0;
      K_ADD:           return (ir[23:21] == 3'd0) && (ir[15:13] == 3'd0) && (ir[7:0] == 8'd0);
      default:         return ir[23:0] == 24'd0;
    endcase
  endfunction
endpackage

// File: rtl/lsm_fetch.sv
module lsm_fetch
  import lsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [7:0]        imem_rdata,
  output logic [ADDR_W-1:0] imem_addr,
  output logic [IW-1:0]     ir,
  output logic              fetch_cycle,
  output logic              fetch_done,
  output logic              exec_phase
);
  localparam int PH_W = $clog2(ILEN + 1);

  logic [PH_W-1:0]   phase;
  logic [ADDR_W-1:0] pc;

  assign imem_addr   = pc;
  assign fetch_cycle = !stall && (phase < PH_W'(ILEN));
  assign fetch_done  = fetch_cycle && (phase == PH_W'(ILEN - 1));
  assign exec_phase  = !stall && (phase == PH_W'(ILEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      pc    <= '0;
      ir    <= '0;
    end else if (exec_phase) begin
      phase <= '0;
    end else if (fetch_cycle) begin
      ir    <= {ir[IW-9:0], imem_rdata};
      pc    <= pc + 1'b1;
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/lsm_decode.sv
module lsm_decode
  import lsm_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic [IW-1:0]     ir,
  output kind_e             kind,
  output logic              legal,
  output logic [RA_W-1:0]   rf1,
  output logic [RA_W-1:0]   rf2,
  output logic [ADDR_W-1:0] addr
);
  logic [7:0] opc;
  logic       known;

  assign opc  = ir[31:24];
  assign rf1  = ir[16 +: RA_W];
  assign rf2  = ir[8 +: RA_W];
  assign addr = ir[ADDR_W-1:0];

  always_comb begin
    known = 1'b1;
    kind  = K_HALT;
    case (opc)
      OPC_LOAD:  kind = K_LOAD;
      OPC_STORE: kind = K_STORE;
      OPC_ADD:   kind = K_ADD;
      OPC_HALT:  kind = K_HALT;
      default:   known = 1'b0;
    endcase
  end

  assign legal = known && pad_clear(kind, ir);
endmodule

// File: rtl/lsm_regfile.sv
module lsm_regfile #(
  parameter int NREG   = 32,
  parameter int DATA_W = 16,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   ra1,
  input  logic [RA_W-1:0]   ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/lsm_core.sv
module lsm_core
  import lsm_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [15:0]       imem_addr,
  input  logic [7:0]        imem_rdata,
  output logic [15:0]       dmem_addr,
  output logic              dmem_re,
  input  logic [15:0]       dmem_rdata,
  output logic              dmem_we,
  output logic [15:0]       dmem_wdata,
  output logic              halted,
  output logic              illegal,
  output logic [CNT_W-1:0]  ibyte_cnt,
  output logic [CNT_W-1:0]  dbyte_cnt
);
  localparam int RA_W = $clog2(NREG);

  logic              halted_q, illegal_q;
  logic [IW-1:0]     ir;
  logic              fetch_cycle, fetch_done, exec_phase, exec_cycle;
  kind_e             kind;
  logic              legal;
  logic [RA_W-1:0]   rf1, rf2;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rd1, rd2, wb_data;
  logic              ld_fire, st_fire, add_fire, stop_evt, rf_we;

  lsm_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (halted_q),
    .imem_rdata (imem_rdata),
    .imem_addr  (imem_addr),
    .ir         (ir),
    .fetch_cycle(fetch_cycle),
    .fetch_done (fetch_done),
    .exec_phase (exec_phase)
  );

  lsm_decode #(.RA_W(RA_W)) u_dec (
    .ir   (ir),
    .kind (kind),
    .legal(legal),
    .rf1  (rf1),
    .rf2  (rf2),
    .addr (addr)
  );

  assign exec_cycle = exec_phase && !halted_q;
  assign ld_fire    = exec_cycle && legal && (kind == K_LOAD);
  assign st_fire    = exec_cycle && legal && (kind == K_STORE);
  assign add_fire   = exec_cycle && legal && (kind == K_ADD);
  assign stop_evt   = exec_cycle && (!legal || (kind == K_HALT));

  assign rf_we   = ld_fire || add_fire;
  assign wb_data = ld_fire ? dmem_rdata : add_wrap(rd1, rd2);

  lsm_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .waddr(rf1),
    .wdata(wb_data),
    .ra1  (rf1),
    .ra2  (rf2),
    .rd1  (rd1),
    .rd2  (rd2)
  );

  assign dmem_addr  = addr;
  assign dmem_re    = ld_fire;
  assign dmem_we    = st_fire;
  assign dmem_wdata = rd1;
  assign halted     = halted_q;
  assign illegal    = illegal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
      ibyte_cnt <= '0;
      dbyte_cnt <= '0;
    end else begin
      if (stop_evt) begin
        halted_q  <= 1'b1;
        illegal_q <= !legal;
      end
      if (fetch_done)         ibyte_cnt <= ibyte_cnt + CNT_W'(ILEN);
      if (ld_fire || st_fire) dbyte_cnt <= dbyte_cnt + CNT_W'(DATA_W / 8);
    end
  end
endmodule

// File: rtl/lsm_core_chk.sv
module lsm_core_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      imem_addr,
  input logic             dmem_re,
  input logic             dmem_we,
  input logic             halted,
  input logic             illegal,
  input logic [CNT_W-1:0] ibyte_cnt,
  input logic [CNT_W-1:0] dbyte_cnt,
  input logic             fetch_cycle,
  input logic             exec_cycle
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dmem_re && dmem_we)); // R11
  AST_STROBE_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n) (dmem_re || dmem_we) |-> exec_cycle); // R11
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (dmem_re || dmem_we) |=> !(dmem_re || dmem_we)); // R11
  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n) fetch_cycle |=> imem_addr == $past(imem_addr) + 16'd1); // R2
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !(dmem_re || dmem_we || fetch_cycle)); // R7
  AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(imem_addr)); // R7
  AST_ILLEGAL_HALTS: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> halted); // R8
  AST_IBYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ibyte_cnt != $past(ibyte_cnt)) |-> ibyte_cnt == $past(ibyte_cnt) + CNT_W'(4)); // R10
  AST_DBYTE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (dmem_re || dmem_we) |=> dbyte_cnt == $past(dbyte_cnt) + CNT_W'(2)); // R10
endmodule

bind lsm_core lsm_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .dmem_re    (dmem_re),
  .dmem_we    (dmem_we),
  .halted     (halted),
  .illegal    (illegal),
  .ibyte_cnt  (ibyte_cnt),
  .dbyte_cnt  (dbyte_cnt),
  .fetch_cycle(fetch_cycle),
  .exec_cycle (exec_cycle)
);

// File: tb/tb_lsm_core.sv
module tb_lsm_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, dmem_addr, dmem_rdata, dmem_wdata;
  logic [7:0]  imem_rdata;
  logic        dmem_re, dmem_we, halted, illegal;
  logic [31:0] ibyte_cnt, dbyte_cnt;

  logic [7:0]  imem [0:511];
  logic [15:0] dm   [0:4095];

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  lsm_core dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .halted(halted), .illegal(illegal),
    .ibyte_cnt(ibyte_cnt), .dbyte_cnt(dbyte_cnt)
  );

  assign imem_rdata = imem[imem_addr[8:0]];
  assign dmem_rdata = dm[dmem_addr[11:0]];

  always @(posedge clk) begin
    if (dmem_we) dm[dmem_addr[11:0]] <= dmem_wdata;
    cyc <= cyc + 1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] i_ld(input int r, input logic [15:0] a);
    return {8'h20, 3'b0, 5'(r), a};
  endfunction
  function automatic logic [31:0] i_st(input int r, input logic [15:0] a);
    return {8'h21, 3'b0, 5'(r), a};
  endfunction
  function automatic logic [31:0] i_add(input int r1, input int r2);
    return {8'h22, 3'b0, 5'(r1), 3'b0, 5'(r2), 8'h00};
  endfunction
  localparam logic [31:0] I_HALT = 32'hFF00_0000;

  task automatic place(input int slot, input logic [31:0] w);
    imem[slot*4]   = w[31:24];
    imem[slot*4+1] = w[23:16];
    imem[slot*4+2] = w[15:8];
    imem[slot*4+3] = w[7:0];
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) imem[i] = 8'h00;
    for (int i = 0; i < 4096; i++) dm[i] = 16'hDEAD;
  endtask

  task automatic hold_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_prog();
    int n = 0;
    @(negedge clk); rst_n = 1'b1;
    while (!halted && n < 3000) begin
      @(negedge clk); n++;
    end
    if (!halted) check("R7 run did not halt", 32'(halted), 32'd1);
  endtask

  function automatic logic [15:0] va(input int a);
    return 16'hF000 + 16'(a * 1021);
  endfunction
  function automatic logic [15:0] vb(input int b);
    return 16'h1F00 + 16'(b * 773);
  endfunction

  function automatic bit pad_bit(input int op, input int b);
    case (op)
      0, 1:    return b >= 21;
      2:       return (b >= 21) || (b >= 13 && b <= 15) || (b <= 7);
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    logic [15:0] pre_pc;
    logic [31:0] pre_ib;
    logic [31:0] t;
    clear_mem();
    hold_reset();
    // R1 reset state
    check("R1 halted", 32'(halted), 0);
    check("R1 illegal", 32'(illegal), 0);
    check("R1 ibyte_cnt", ibyte_cnt, 0);
    check("R1 dbyte_cnt", dbyte_cnt, 0);
    check("R1 imem_addr", 32'(imem_addr), 0);
    check("R1 strobes", 32'({dmem_re, dmem_we}), 0);

    // R3 R4 R6: load every register, store every register back
    for (int i = 0; i < 32; i++) begin
      dm[12'hA00 + i] = 16'h4000 + 16'(i * 257);
      place(i, i_ld(i, 16'h0A00 + 16'(i)));
      place(32 + i, i_st(i, 16'h0B00 + 16'(i)));
    end
    place(64, I_HALT);
    run_prog();
    for (int i = 0; i < 32; i++)
      check(i == 0 ? "R6 reg0 round trip" : "R3 R4 load-store round trip",
            32'(dm[12'hB00 + i]), 32'(16'h4000 + 16'(i * 257)));
    check("R7 halted", 32'(halted), 1);
    check("R7 illegal low", 32'(illegal), 0);
    check("R2 pc after halt", 32'(imem_addr), 32'd260);
    check("R10 ibyte_cnt", ibyte_cnt, 32'd260);
    check("R10 dbyte_cnt", dbyte_cnt, 32'd128);
    pre_pc = imem_addr; pre_ib = ibyte_cnt;
    repeat (20) @(negedge clk);
    check("R7 pc frozen", 32'(imem_addr), 32'(pre_pc));
    check("R7 ibyte frozen", ibyte_cnt, pre_ib);

    // R2 big-endian address: high byte must select
    clear_mem();
    dm[12'h312] = 16'h1357; dm[12'h123] = 16'h0BAD;
    place(0, i_ld(7, 16'h0312)); place(1, i_st(7, 16'h0456)); place(2, I_HALT);
    hold_reset(); run_prog();
    check("R2 R3 address byte order", 32'(dm[12'h456]), 32'h1357);

    // R5 R6 R10: every register pair through add
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        logic [15:0] exp;
        int s;
        clear_mem();
        dm[12'h100] = va(a); dm[12'h200] = vb(b);
        s = 0;
        place(s++, i_ld(a, 16'h0100));
        if (a != b) place(s++, i_ld(b, 16'h0200));
        place(s++, i_add(a, b));
        place(s++, i_st(a, 16'h0300));
        place(s++, I_HALT);
        hold_reset(); run_prog();
        exp = (a == b) ? 16'(va(a) * 2) : 16'(va(a) + vb(b));
        check((a == 0 || b == 0) ? "R6 R5 add with reg0" : "R5 wrapped add",
              32'(dm[12'h300]), 32'(exp));
        check("R10 ibyte per program", ibyte_cnt, 32'(s * 4));
        check("R10 dbyte per program", dbyte_cnt, (a == b) ? 32'd4 : 32'd6);
      end
    end

    // R8: every padding bit of every opcode
    for (int op = 0; op < 4; op++) begin
      for (int b = 0; b < 24; b++) begin
        if (pad_bit(op, b)) begin
          clear_mem();
          dm[12'h123] = 16'h5A5A;
          case (op)
            0: t = i_ld(5, 16'h0456);
            1: t = i_st(5, 16'h0789);
            2: t = i_add(5, 5);
            default: t = I_HALT;
          endcase
          t[b] = 1'b1;
          place(0, i_ld(5, 16'h0123));
          place(1, t);
          place(2, i_st(5, 16'h0ABC));
          place(3, I_HALT);
          hold_reset(); run_prog();
          check("R8 illegal flag", 32'(illegal), 1);
          check("R8 halted", 32'(halted), 1);
          check("R8 no store from bad slot", 32'(dm[12'h789]), 32'hDEAD);
          check("R8 no later store", 32'(dm[12'hABC]), 32'hDEAD);
          check("R8 R10 ibyte", ibyte_cnt, 32'd8);
          check("R8 R10 dbyte", dbyte_cnt, 32'd2);
        end
      end
    end

    // R9: every unknown opcode
    for (int o = 0; o < 256; o++) begin
      if (o != 8'h20 && o != 8'h21 && o != 8'h22 && o != 8'hFF) begin
        clear_mem();
        place(0, {8'(o), 24'h0});
        hold_reset(); run_prog();
        check("R9 unknown opcode illegal", 32'({halted, illegal}), 32'd3);
        check("R9 R10 ibyte", ibyte_cnt, 32'd4);
        check("R9 R10 dbyte", dbyte_cnt, 32'd0);
      end
    end

    summary();
  end
endmodule